// File: doc/BRIEF.md
# Fractional Clock Rate Controller

This block thins a running clock into a lower average rate. It slices time into frames of 32 input clock cycles. In each frame it raises a pass enable for a chosen number of cycles and holds it low for the rest. A downstream clock-gating cell uses that enable to let the chosen pulses through and swallow the others. The resulting average rate is the input rate times a multiplier, divided by 32. The cycles that pass are spread as evenly as an accumulator allows, so they do not bunch at one end of the frame.

Software controls the block through two 32-bit registers. The rate register holds a 5-bit code, and the multiplier is 32 minus that code. A code of zero therefore means full rate. The control register holds a self-clearing kick flag. To change the rate, software first writes the code and then sets the kick flag. The block takes the stored code on the last cycle of the current frame, clears the kick flag in the same clock edge, and uses the new multiplier from the first cycle of the next frame. Software polls the kick flag to learn when the change has completed. While a change is pending, the code is frozen and a second kick is refused.

Top module: `frac_rate_ctrl`

## Requirements
- R1: After reset, both registers read 0, the kick flag is clear and the multiplier is 32, so the pass enable is high on every cycle.
- R2: The rate code sits in bits 12:8 of the rate register (regSel = 0). The multiplier is 32 minus the code, so code 0 gives 32 passes per frame and code 31 gives 1.
- R3: The kick flag is bit 31 of the control register (regSel = 1). Writing 1 to that bit sets the flag, which then reads back as 1. Writing 0 to that bit never clears the flag.
- R4: A pending kick is taken on the last cycle of a frame. The flag reads 1 up to and including that cycle and reads 0 from the first cycle of the next frame, and the new multiplier governs the whole of that next frame.
- R5: While the kick flag is set, writes to bits 12:8 of the rate register leave the code unchanged. The other bits of the same write are still stored.
- R6: Changing the code without a kick has no effect on the pass enable.
- R7: Frame positions k = 0..31 count from the first cycle after reset. With multiplier m, the enable is high at position k exactly when floor((k+1)·m/32) > floor(k·m/32). This gives exactly m passes per frame.
- R8: All register bits outside the code field and the kick flag are plain read/write storage and read back as written.
- R9: Writing kick = 1 while a change is already pending is refused. The pending change still completes at the end of the same frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock whose pulses are passed or swallowed |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, taken on the rising clock edge |
| regSel | input | 1 | Register select: 0 = rate register, 1 = control register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data of the selected register |
| pulseEn | output | 1 | Pass enable for the current input clock cycle |

## Verification
The assertions check the following on every cycle:
- the kick flag holds until a frame end and clears exactly there;
- the active multiplier moves only on an apply strobe;
- the code field stays frozen while a change is pending;
- the number of passes in each frame equals the active multiplier.

The bench's scenarios cover the rest. They check the exact position of every pass within a frame for several multipliers, including 1 and 32. They check the read-back of the storage bits. They also check what software sees when it polls: kick still set on the last cycle of the frame and clear on the next, a refused second kick, and a frozen code while a change is pending.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;
  // log2 of the frame length in input clock cycles
  parameter int FRAME_LOG2 = 5;
  localparam int MULT_W = FRAME_LOG2 + 1;

  // command from the control module to the datapath
  typedef struct packed {
    logic              apply;
    logic [MULT_W-1:0] mult;
  } rateCmd_t;
endpackage

// File: rtl/frac_rate_regs.sv
module frac_rate_regs
  import frac_rate_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int CODE_LSB = 8,
  parameter int KICK_BIT = 31
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  regSel,
  input  logic [REG_W-1:0]      wrData,
  input  logic                  frameEnd,
  output logic [REG_W-1:0]      rdData,
  output rateCmd_t              cmd,
  output logic                  kickPend,
  output logic [FRAME_LOG2-1:0] codeField
);
  localparam logic [MULT_W-1:0] FULL_MULT = MULT_W'(1 << FRAME_LOG2);
  localparam logic [REG_W-1:0]  KICK_MASK = REG_W'(1) << KICK_BIT;

  logic [REG_W-1:0] rateReg;
  logic [REG_W-1:0] ctrlStore;
  logic [REG_W-1:0] rateNext;
  logic             applyNow;
  logic             kickReq;

  assign codeField = rateReg[CODE_LSB +: FRAME_LOG2];
  assign applyNow  = kickPend && frameEnd;
  assign kickReq   = wrEn && regSel && wrData[KICK_BIT];

  // code field is frozen while a change is pending
  always_comb begin
    rateNext = wrData;
    if (kickPend) rateNext[CODE_LSB +: FRAME_LOG2] = codeField;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateReg   <= '0;
      ctrlStore <= '0;
      kickPend  <= 1'b0;
    end else begin
      if (wrEn && !regSel) rateReg <= rateNext;
      if (wrEn && regSel)  ctrlStore <= wrData & ~KICK_MASK;
      if (applyNow)        kickPend <= 1'b0;
      else if (kickReq)    kickPend <= 1'b1;
    end
  end

  assign cmd.apply = applyNow;
  assign cmd.mult  = FULL_MULT - MULT_W'(codeField);

  assign rdData = regSel ? (ctrlStore | (kickPend ? KICK_MASK : '0)) : rateReg;
endmodule

// File: rtl/frac_rate_dp.sv
module frac_rate_dp
  import frac_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rateCmd_t          cmd,
  output logic              pulseEn,
  output logic              frameEnd,
  output logic [MULT_W-1:0] activeMult
);
  localparam logic [MULT_W-1:0] FULL_MULT = MULT_W'(1 << FRAME_LOG2);

  logic [FRAME_LOG2-1:0] frameCnt;
  logic [FRAME_LOG2-1:0] acc;
  logic [MULT_W-1:0]     sum;

  assign sum      = {1'b0, acc} + activeMult;
  assign pulseEn  = sum[FRAME_LOG2];
  assign frameEnd = &frameCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt   <= '0;
      acc        <= '0;
      activeMult <= FULL_MULT;
    end else begin
      frameCnt <= frameCnt + 1'b1;
      acc      <= sum[FRAME_LOG2-1:0];
      if (cmd.apply) activeMult <= cmd.mult;
    end
  end
endmodule

// File: rtl/frac_rate_ctrl.sv
module frac_rate_ctrl
  import frac_rate_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int CODE_LSB = 8,
  parameter int KICK_BIT = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             pulseEn
);
  rateCmd_t              cmd;
  logic                  frameEnd;
  logic                  kickPend;
  logic [FRAME_LOG2-1:0] codeField;
  logic [MULT_W-1:0]     activeMult;

  frac_rate_regs #(
    .REG_W(REG_W), .CODE_LSB(CODE_LSB), .KICK_BIT(KICK_BIT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .frameEnd(frameEnd), .rdData(rdData), .cmd(cmd), .kickPend(kickPend),
    .codeField(codeField)
  );

  frac_rate_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pulseEn(pulseEn),
    .frameEnd(frameEnd), .activeMult(activeMult)
  );
endmodule

// File: rtl/frac_rate_chk.sv
module frac_rate_chk
  import frac_rate_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int KICK_BIT = 31
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  regSel,
  input logic [REG_W-1:0]      wrData,
  input logic                  pulseEn,
  input logic                  frameEnd,
  input logic                  kickPend,
  input logic                  applyNow,
  input logic [FRAME_LOG2-1:0] codeField,
  input logic [MULT_W-1:0]     activeMult
);
  logic [MULT_W-1:0] passCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         passCnt <= '0;
    else if (frameEnd) passCnt <= '0;
    else               passCnt <= passCnt + MULT_W'(pulseEn);
  end

  // R3: a kick write with nothing pending sets the flag
  a_r3_kick_sets: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel && wrData[KICK_BIT] && !kickPend) |=> kickPend);

  // R4: a pending kick is held until a frame end
  a_r4_kick_holds: assert property (@(posedge clk) disable iff (!rstN)
    (kickPend && !frameEnd) |=> kickPend);

  // R4: a pending kick clears at the frame end
  a_r4_kick_clears: assert property (@(posedge clk) disable iff (!rstN)
    (kickPend && frameEnd) |=> !kickPend);

  // R5: the code stays frozen while a change is pending
  a_r5_code_frozen: assert property (@(posedge clk) disable iff (!rstN)
    kickPend |=> $stable(codeField));

  // R6: the multiplier moves only on an apply strobe
  a_r6_mult_stable: assert property (@(posedge clk) disable iff (!rstN)
    !applyNow |=> $stable(activeMult));

  // R7: each frame carries exactly the active multiplier of passes
  a_r7_frame_count: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> ((passCnt + MULT_W'(pulseEn)) == activeMult));
endmodule

bind frac_rate_ctrl frac_rate_chk #(.REG_W(REG_W), .KICK_BIT(KICK_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
  .pulseEn(pulseEn), .frameEnd(frameEnd), .kickPend(kickPend),
  .applyNow(cmd.apply), .codeField(codeField), .activeMult(activeMult)
);

// File: tb/frac_rate_ctrl_tb.sv
`timescale 1ns/100ps
module frac_rate_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic        regSel;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        pulseEn;

  int  nChecks = 0;
  int  nFails  = 0;
  logic [4:0] benchPos;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  frac_rate_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .pulseEn(pulseEn)
  );

  // frame position, counted from the first cycle after reset (R7)
  always @(posedge clk) begin
    if (!rstN) benchPos <= '0;
    else       benchPos <= benchPos + 1'b1;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (t=%0t pos=%0d)",
               tag, act, exp, $time, benchPos);
    end
  endtask

  function automatic string tagName(input int id);
    case (id)
      1:       return "R1";
      2:       return "R2 R7";
      5:       return "R5";
      default: return "R6";
    endcase
  endfunction

  // monitor: pops one expected enable per cycle
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      logic [7:0] item;
      item = expQ.pop_front();
      check(pulseEn === item[0], tagName(int'(item[7:1])),
            32'(pulseEn), 32'(item[0]));
    end
  end

  // driver: expected enables for n frames starting at the next frame
  task automatic expectFrames(input int m, input int n, input int id);
    while (benchPos != 5'd31) @(negedge clk);
    #0.5;
    for (int f = 0; f < n; f++) begin
      for (int k = 0; k < 32; k++) begin
        logic b;
        b = (((k + 1) * m) / 32) != ((k * m) / 32);
        expQ.push_back({7'(id), b});
      end
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic waitPos(input int p);
    @(negedge clk);
    while (benchPos != 5'(p)) @(negedge clk);
  endtask

  task automatic writeReg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [31:0] d);
    regSel = sel;
    #0.5;
    d = rdData;
  endtask

  task automatic applyCode(input int code);
    logic [31:0] d;
    waitPos(2);
    writeReg(1'b0, 32'(code) << 8);
    writeReg(1'b1, 32'h8000_0000);
    readReg(1'b1, d);
    check(d[31] == 1'b1, "R3", d, 32'h8000_0000);
    while (benchPos != 5'd31) @(negedge clk);
    readReg(1'b1, d);
    check(d[31] == 1'b1, "R4", d, 32'h8000_0000);
    expectFrames(32 - code, 2, 2);
    @(negedge clk);
    readReg(1'b1, d);
    check(d[31] == 1'b0, "R4", d, 32'h0);
    drain();
  endtask

  initial begin
    logic [31:0] d;
    rstN = 1'b0; wrEn = 1'b0; regSel = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state and full rate
    readReg(1'b0, d); check(d == 32'h0, "R1", d, 32'h0);
    readReg(1'b1, d); check(d == 32'h0, "R1", d, 32'h0);
    expectFrames(32, 1, 1);
    drain();

    // R8, R6: storage read-back, code without kick does nothing
    waitPos(2);
    writeReg(1'b0, 32'h0000_18A5);
    readReg(1'b0, d); check(d == 32'h0000_18A5, "R8", d, 32'h0000_18A5);
    expectFrames(32, 1, 6);
    drain();

    // R3, R5, R8, R9: kick with frozen code and a refused second kick
    waitPos(2);
    writeReg(1'b1, 32'h8000_1234);
    readReg(1'b1, d); check(d == 32'h8000_1234, "R3 R8", d, 32'h8000_1234);
    writeReg(1'b0, 32'h0000_0F5A);
    readReg(1'b0, d); check(d == 32'h0000_185A, "R5", d, 32'h0000_185A);
    writeReg(1'b1, 32'h0000_00C3);
    readReg(1'b1, d); check(d == 32'h8000_00C3, "R3", d, 32'h8000_00C3);
    writeReg(1'b1, 32'h8000_0000);
    readReg(1'b1, d); check(d == 32'h8000_0000, "R9", d, 32'h8000_0000);
    while (benchPos != 5'd31) @(negedge clk);
    readReg(1'b1, d); check(d[31] == 1'b1, "R9", d, 32'h8000_0000);
    expectFrames(8, 2, 5);
    @(negedge clk);
    readReg(1'b1, d); check(d == 32'h0, "R9 R4", d, 32'h0);
    drain();

    // R2, R7: several multipliers, including the extremes
    applyCode(31);
    applyCode(13);
    applyCode(24);
    applyCode(0);

    // R6: a new code without a kick leaves full rate in place
    waitPos(2);
    writeReg(1'b0, 32'h0000_0500);
    expectFrames(32, 1, 6);
    drain();

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule